// File: doc/BRIEF.md
# Slot-Table System Bus Arbiter with Split Support

This block decides which master owns a shared AHB-style system bus. Ownership walks through a programmable table of reservation channels. Each channel is one byte: an enable flag, a 2-bit share code and a master number. A master listed in several enabled channels gets a proportionally larger slice of the bus. On every arbitration round the table pointer moves forward to the next channel that can actually use its turn. Channels that are disabled, whose master is idle, or whose master is held off by a split are passed over. When nothing in the table is eligible, the bus parks on master 0, which is the default master.

Split handling sits on top of the table. A slave that cannot finish a transfer reports a split against a master and names itself. From then on that master cannot win, and any other master whose pending request targets the same slave is also held back. When the slave raises that master's bit in the 16-bit resume vector, the master is released. In the very next round it outranks the table. A watchdog counts consecutive IDLE cycles while the bus is parked and reports a timeout either as an interrupt pulse or as a reset-request pulse.

The request/grant pair is the only handshake. A master keeps `req` high until it sees its `grant` bit. The only stall that reaches the arbiter is `bus_ready` low, which freezes the grant. There is no data stream and no valid/ready interface.

Top module: `slot_bus_arbiter`

## Requirements
- R1: While and directly after reset, `grant_idx` is 0, `grant` is 4'b0001, `parked` is 1 and both timeout outputs are 0.
- R2: Channel c sits in word c/4 of `chan_cfg` (word k is bits [32k+31:32k]), in byte lane 3-(c%4), so channel 0 is bits [31:24]. In each byte, bit 7 enables the channel, bits 5:4 are the share code and bits 3:0 are the master number. Enabled channels are visited in rising order, starting after the last winning channel and wrapping around. Disabled channels are never granted, and a master may hold several channels.
- R3: A channel whose master is not requesting, is split-masked, is blocked, or has a number of N_MST or more gives up its turn to the next channel in order.
- R4: Every channel has a 2-bit turn counter, cleared by reset. The counter advances each time the channel is offered a turn with an eligible master, up to and including the winning channel. Share code 00 always takes the turn, 01 takes it unless the counter is 3, 10 takes it when the counter is even, and 11 takes it only when the counter is 0.
- R5: Arbitration happens only on a clock edge where `bus_ready` is 1, `bus_lock` is 0, and either `bus_trans` is IDLE (2'b00) or `xfer_last` is 1. On every other edge the grant holds.
- R6: After `split_rsp` names master m, master m is never granted until a resume for m arrives.
- R7: While a split against slave s is outstanding, any master whose `req_slv` field equals s is not eligible.
- R8: A resume bit for a masked master releases it and gives it top priority in the next arbitration round only. A resume bit for a master that is not masked has no effect.
- R9: If no channel and no boosted master is eligible in a round, the grant goes to master 0 and `parked` is 1. Otherwise `parked` is 0.
- R10: While parked with `bus_trans` IDLE, a counter runs. A transfer start (NONSEQ with `bus_ready`) or leaving park clears it. A timeout pulses once, one cycle long, after `tmo_limit` consecutive idle cycles. A limit of 0 disables the timeout.
- R11: The timeout pulse appears on `tmo_irq` when `tmo_to_reset` is 0 and on `tmo_rst` when it is 1, never on both.
- R12: `grant` is always one-hot and its set bit equals `grant_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Per-master bus request |
| req_slv | input | N_MST*log2(N_SLV) | Target slave of each master's pending request |
| bus_ready | input | 1 | Transfer-ready of the bus |
| bus_trans | input | 2 | Current transfer type (00 IDLE, 10 NONSEQ) |
| xfer_last | input | 1 | Current transfer is in its final beat |
| bus_lock | input | 1 | Current owner holds a locked sequence |
| split_rsp | input | 1 | Slave issues a split this cycle |
| split_mst | input | 4 | Master being split |
| split_slv | input | log2(N_SLV) | Slave issuing the split |
| split_resume | input | 16 | Per-master resume bits from slaves |
| chan_cfg | input | ceil(N_CH/4)*32 | Packed reservation-channel table |
| tmo_limit | input | TMO_W | Idle cycles before timeout, 0 disables |
| tmo_to_reset | input | 1 | Route timeout to reset request |
| grant | output | N_MST | One-hot grant |
| grant_idx | output | log2(N_MST) | Index of granted master |
| parked | output | 1 | Bus is parked on the default master |
| tmo_irq | output | 1 | Timeout interrupt pulse |
| tmo_rst | output | 1 | Timeout reset-request pulse |

## Verification
The bench drives sequences in which the pointer must wrap, must skip idle or masked owners, and must credit a master that holds two channels. A design that rescans from channel 0, or that lets an idle owner keep its turn, produces a different grant order. Each non-100% share code is run long enough for its counter to wrap, which exposes a wrong take pattern or a counter that moves only on wins. Split cases check that both the split master and a bystander aimed at the same slave are held off, that the released master jumps the table exactly once, and that a stray resume for an unmasked master changes nothing. The timeout cases check a pulse that comes too early, comes twice, is not cleared by a NONSEQ start, or goes to the wrong output.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef enum logic [1:0] {
    SHARE_ALL  = 2'b00,
    SHARE_3Q   = 2'b01,
    SHARE_HALF = 2'b10,
    SHARE_1Q   = 2'b11
  } share_e;

  typedef struct packed {
    logic       en;
    logic       spare;
    share_e     share;
    logic [3:0] mst;
  } slot_t;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  function automatic logic share_take(input share_e code, input logic [1:0] turn);
    case (code)
      SHARE_ALL:  return 1'b1;
      SHARE_3Q:   return turn != 2'd3;
      SHARE_HALF: return ~turn[0];
      default:    return turn == 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/split_tracker.sv
module split_tracker #(
  parameter int N_MST = 4,
  parameter int SLV_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   split_rsp,
  input  logic [3:0]             split_mst,
  input  logic [SLV_W-1:0]       split_slv,
  input  logic [15:0]            split_resume,
  input  logic                   round_done,
  input  logic [N_MST*SLV_W-1:0] req_slv,
  output logic [N_MST-1:0]       masked,
  output logic [N_MST-1:0]       boost,
  output logic [N_MST-1:0]       blocked
);

  localparam int NS = 1 << SLV_W;

  logic [SLV_W-1:0] home_q [N_MST];
  logic [NS-1:0]    slv_busy;
  logic             unused_resume;

  assign unused_resume = ^split_resume;

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    logic hit, wake;
    assign hit  = split_rsp && (split_mst == 4'(m));
    assign wake = split_resume[m] && masked[m];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        masked[m] <= 1'b0;
        boost[m]  <= 1'b0;
        home_q[m] <= '0;
      end else begin
        if (hit) begin
          masked[m] <= 1'b1;
          home_q[m] <= split_slv;
        end else if (wake) begin
          masked[m] <= 1'b0;
        end
        if (wake)            boost[m] <= 1'b1;
        else if (round_done) boost[m] <= 1'b0;
      end
    end

    assign blocked[m] = slv_busy[req_slv[m*SLV_W +: SLV_W]];

    // R6: a masked master stays masked until its resume bit arrives
    p_mask_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (masked[m] && !split_resume[m]) |=> masked[m]);

    // R8: a resume of a masked master releases and boosts it
    p_resume_boost_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (split_resume[m] && masked[m] && !hit) |=> (boost[m] && !masked[m]));

    // R8: a resume of an unmasked master does not create a boost
    p_stray_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (split_resume[m] && !masked[m] && !boost[m]) |=> !boost[m]);
  end

  always_comb begin
    slv_busy = '0;
    for (int m = 0; m < N_MST; m++) begin
      if (masked[m]) slv_busy[home_q[m]] = 1'b1;
    end
  end

endmodule

// File: rtl/slot_picker.sv
module slot_picker
  import slot_arb_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int N_CH  = 8,
  localparam int MW   = $clog2(N_MST),
  localparam int CW   = $clog2(N_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  slot_t [N_CH-1:0]    slots,
  input  logic  [N_MST-1:0]   elig,
  input  logic                advance,
  output logic                found,
  output logic  [MW-1:0]      win_mst
);

  logic [CW-1:0] ptr_q;
  logic [CW-1:0] win_ch;
  logic [1:0]    turn_q [N_CH];
  logic [N_CH-1:0] offered, take, bump;
  logic          unused_spare;

  always_comb begin
    unused_spare = 1'b0;
    for (int c = 0; c < N_CH; c++) unused_spare = unused_spare ^ slots[c].spare;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign offered[c] = slots[c].en && (int'(slots[c].mst) < N_MST)
                        && elig[slots[c].mst[MW-1:0]];
    assign take[c]    = offered[c] && share_take(slots[c].share, turn_q[c]);
  end

  always_comb begin
    logic [CW-1:0] idx;
    found  = 1'b0;
    win_ch = '0;
    bump   = '0;
    for (int k = 0; k < N_CH; k++) begin
      idx = CW'((int'(ptr_q) + 1 + k) % N_CH);
      if (!found) bump[idx] = offered[idx];
      if (!found && take[idx]) begin
        found  = 1'b1;
        win_ch = idx;
      end
    end
    win_mst = slots[win_ch].mst[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= CW'(N_CH - 1);
      for (int c = 0; c < N_CH; c++) turn_q[c] <= 2'd0;
    end else if (advance) begin
      for (int c = 0; c < N_CH; c++) begin
        if (bump[c]) turn_q[c] <= turn_q[c] + 2'd1;
      end
      if (found) ptr_q <= win_ch;
    end
  end

  // R2: a winning channel is enabled and its master is eligible
  p_win_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (slots[win_ch].en && elig[win_mst]));

  // R4: the winning channel is always among those whose turn counter moves
  p_win_bumped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> bump[win_ch]);

endmodule

// File: rtl/idle_watch.sv
module idle_watch
  import slot_arb_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parked,
  input  logic [1:0]       bus_trans,
  input  logic             bus_ready,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tmo_to_reset,
  output logic             tmo_irq,
  output logic             tmo_rst
);

  logic [TMO_W-1:0] cnt_q;
  logic idle_now, xfer_start, fire;

  assign idle_now   = parked && (bus_trans == TR_IDLE);
  assign xfer_start = bus_ready && (bus_trans == TR_NONSEQ);
  assign fire       = idle_now && (tmo_limit != '0) && (cnt_q == tmo_limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tmo_irq <= 1'b0;
      tmo_rst <= 1'b0;
    end else begin
      if (!parked || xfer_start)              cnt_q <= '0;
      else if (idle_now && cnt_q != tmo_limit) cnt_q <= cnt_q + 1'b1;
      tmo_irq <= fire && !tmo_to_reset;
      tmo_rst <= fire && tmo_to_reset;
    end
  end

  // R11: the event goes to one destination only
  p_one_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmo_irq && tmo_rst));

  // R10: the timeout is a single-cycle pulse
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_irq || tmo_rst) |=> !(tmo_irq || tmo_rst));

endmodule

// File: rtl/slot_bus_arbiter.sv
module slot_bus_arbiter
  import slot_arb_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int N_CH  = 8,
  parameter int N_SLV = 4,
  parameter int TMO_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_MST-1:0]                     req,
  input  logic [N_MST*$clog2(N_SLV)-1:0]       req_slv,
  input  logic                                 bus_ready,
  input  logic [1:0]                           bus_trans,
  input  logic                                 xfer_last,
  input  logic                                 bus_lock,
  input  logic                                 split_rsp,
  input  logic [3:0]                           split_mst,
  input  logic [$clog2(N_SLV)-1:0]             split_slv,
  input  logic [15:0]                          split_resume,
  input  logic [((N_CH+3)/4)*32-1:0]           chan_cfg,
  input  logic [TMO_W-1:0]                     tmo_limit,
  input  logic                                 tmo_to_reset,
  output logic [N_MST-1:0]                     grant,
  output logic [$clog2(N_MST)-1:0]             grant_idx,
  output logic                                 parked,
  output logic                                 tmo_irq,
  output logic                                 tmo_rst
);

  localparam int MW    = $clog2(N_MST);
  localparam int SLV_W = $clog2(N_SLV);

  slot_t [N_CH-1:0] slots;
  logic [N_MST-1:0] masked, boost, blocked, elig;
  logic             arb_fire, found, boost_hit, nxt_park, advance;
  logic [MW-1:0]    win_mst, nxt_idx;

  for (genvar c = 0; c < N_CH; c++) begin : g_unpack
    assign slots[c] = chan_cfg[(c/4)*32 + (3-(c%4))*8 +: 8];
  end

  assign arb_fire = bus_ready && !bus_lock && ((bus_trans == TR_IDLE) || xfer_last);
  assign elig     = req & ~masked & ~blocked;
  assign advance  = arb_fire && !boost_hit;

  split_tracker #(.N_MST(N_MST), .SLV_W(SLV_W)) u_split (
    .clk          (clk),
    .rst_n        (rst_n),
    .split_rsp    (split_rsp),
    .split_mst    (split_mst),
    .split_slv    (split_slv),
    .split_resume (split_resume),
    .round_done   (arb_fire),
    .req_slv      (req_slv),
    .masked       (masked),
    .boost        (boost),
    .blocked      (blocked)
  );

  slot_picker #(.N_MST(N_MST), .N_CH(N_CH)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .slots   (slots),
    .elig    (elig),
    .advance (advance),
    .found   (found),
    .win_mst (win_mst)
  );

  always_comb begin
    boost_hit = 1'b0;
    nxt_idx   = '0;
    nxt_park  = 1'b1;
    for (int m = N_MST - 1; m >= 0; m--) begin
      if (boost[m] && elig[m]) begin
        boost_hit = 1'b1;
        nxt_idx   = MW'(m);
      end
    end
    if (boost_hit) begin
      nxt_park = 1'b0;
    end else if (found) begin
      nxt_idx  = win_mst;
      nxt_park = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_idx <= '0;
      parked    <= 1'b1;
    end else if (arb_fire) begin
      grant_idx <= nxt_idx;
      parked    <= nxt_park;
    end
  end

  always_comb begin
    grant = '0;
    grant[grant_idx] = 1'b1;
  end

  idle_watch #(.TMO_W(TMO_W)) u_watch (
    .clk          (clk),
    .rst_n        (rst_n),
    .parked       (parked),
    .bus_trans    (bus_trans),
    .bus_ready    (bus_ready),
    .tmo_limit    (tmo_limit),
    .tmo_to_reset (tmo_to_reset),
    .tmo_irq      (tmo_irq),
    .tmo_rst      (tmo_rst)
  );

  // R5: without an arbitration opportunity the owner does not change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_fire |=> $stable(grant_idx));

  // R12: exactly one grant line is active
  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  // R6, R7: a real (non-parked) winner is requesting and neither masked nor blocked
  p_winner_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_fire && !nxt_park) |-> (req[nxt_idx] && !masked[nxt_idx] && !blocked[nxt_idx]));

  // R9: the parked owner is always the default master
  p_park_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> (grant_idx == '0));

endmodule

// File: tb/slot_bus_arbiter_bench.sv
module slot_bus_arbiter_bench;

  localparam int N_MST = 4;
  localparam int N_CH  = 8;
  localparam int N_SLV = 4;
  localparam int TMO_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [7:0]  req_slv = '0;
  logic        bus_ready = 1'b0;
  logic [1:0]  bus_trans = 2'b00;
  logic        xfer_last = 1'b0;
  logic        bus_lock = 1'b0;
  logic        split_rsp = 1'b0;
  logic [3:0]  split_mst = '0;
  logic [1:0]  split_slv = '0;
  logic [15:0] split_resume = '0;
  logic [63:0] chan_cfg = '0;
  logic [15:0] tmo_limit = '0;
  logic        tmo_to_reset = 1'b0;
  logic [3:0]  grant;
  logic [1:0]  grant_idx;
  logic        parked, tmo_irq, tmo_rst;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { int exp; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  slot_bus_arbiter #(.N_MST(N_MST), .N_CH(N_CH), .N_SLV(N_SLV), .TMO_W(TMO_W)) u_slot_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .req_slv(req_slv), .bus_ready(bus_ready),
    .bus_trans(bus_trans), .xfer_last(xfer_last), .bus_lock(bus_lock),
    .split_rsp(split_rsp), .split_mst(split_mst), .split_slv(split_slv),
    .split_resume(split_resume), .chan_cfg(chan_cfg), .tmo_limit(tmo_limit),
    .tmo_to_reset(tmo_to_reset), .grant(grant), .grant_idx(grant_idx),
    .parked(parked), .tmo_irq(tmo_irq), .tmo_rst(tmo_rst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each expected owner one negedge after it was queued
  always @(negedge clk) begin : mon
    exp_t e;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      check((int'(grant_idx) == e.exp) && (grant == (4'b1 << e.exp)), e.tag,
            int'(grant_idx), e.exp);
    end
  end

  function automatic logic [63:0] put_ch(input logic [63:0] v, input int c,
                                         input logic [1:0] share, input int m);
    logic [63:0] r;
    r = v;
    r[(c/4)*32 + (3-(c%4))*8 +: 8] = {1'b1, 1'b0, share, 4'(m)};
    return r;
  endfunction

  task automatic sync();
    @(negedge clk); #1;
    split_rsp    = 1'b0;
    split_resume = '0;
  endtask

  task automatic do_reset(input logic [63:0] cfg);
    sync();
    rst_n = 1'b0; bus_ready = 1'b0; bus_trans = 2'b00; xfer_last = 1'b0; bus_lock = 1'b0;
    chan_cfg = cfg;
    repeat (3) sync();
    rst_n = 1'b1;
  endtask

  // one arbitration round, queues the expected owner
  task automatic arb(input int exp, input string tag);
    exp_t e;
    sync();
    bus_ready = 1'b1; bus_trans = 2'b00; xfer_last = 1'b0; bus_lock = 1'b0;
    e.exp = exp; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // non-arbitration cycle (mid-burst), queues the owner expected to hold
  task automatic busy_cycle(input int exp, input string tag);
    exp_t e;
    sync();
    bus_ready = 1'b1; bus_trans = 2'b10; xfer_last = 1'b0; bus_lock = 1'b0;
    e.exp = exp; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run_seq(input int seq[], input string tag);
    foreach (seq[i]) arb(seq[i], tag);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [63:0] cfg;
    int irq_n, rst_n_cnt, early;

    // R1: reset state
    cfg = '0;
    cfg = put_ch(cfg, 0, 2'b00, 0);
    cfg = put_ch(cfg, 1, 2'b00, 1);
    cfg = put_ch(cfg, 2, 2'b00, 0);
    cfg = put_ch(cfg, 3, 2'b00, 2);
    do_reset(cfg);
    check(grant_idx == 2'd0 && grant == 4'b0001, "R1 grant after reset", int'(grant), 1);
    check(parked == 1'b1, "R1 parked after reset", int'(parked), 1);
    check(!tmo_irq && !tmo_rst, "R1 timeout idle", int'({tmo_irq, tmo_rst}), 0);

    // R2: rotation with master 0 in two channels, master 3 not in table
    req = 4'b1111;
    run_seq('{0, 1, 0, 2, 0, 1, 0, 2}, "R2 rotation");

    // R3: idle owners forfeit
    do_reset(cfg);
    req = 4'b0110;
    run_seq('{1, 2, 1, 2}, "R3 forfeit");

    // R5: hold conditions, then a last-beat handover
    do_reset(cfg);
    req = 4'b1111;
    arb(0, "R5 first");
    sync(); bus_ready = 1'b1; bus_trans = 2'b00; bus_lock = 1'b1;
    begin exp_t e; e.exp = 0; e.tag = "R5 locked hold"; exp_q.push_back(e); end
    sync(); bus_ready = 1'b0; bus_trans = 2'b00; bus_lock = 1'b0;
    begin exp_t e; e.exp = 0; e.tag = "R5 not-ready hold"; exp_q.push_back(e); end
    busy_cycle(0, "R5 mid-burst hold");
    sync(); bus_ready = 1'b1; bus_trans = 2'b11; xfer_last = 1'b1; bus_lock = 1'b0;
    begin exp_t e; e.exp = 1; e.tag = "R5 last-beat handover"; exp_q.push_back(e); end

    // R4: share codes on channel 0 (master 1), channel 1 full share (master 2)
    cfg = '0; cfg = put_ch(cfg, 0, 2'b10, 1); cfg = put_ch(cfg, 1, 2'b00, 2);
    do_reset(cfg); req = 4'b0110;
    run_seq('{1, 2, 2, 1, 2, 2, 1}, "R4 half share");
    cfg = '0; cfg = put_ch(cfg, 0, 2'b11, 1); cfg = put_ch(cfg, 1, 2'b00, 2);
    do_reset(cfg); req = 4'b0110;
    run_seq('{1, 2, 2, 2, 2, 1}, "R4 quarter share");
    cfg = '0; cfg = put_ch(cfg, 0, 2'b01, 1); cfg = put_ch(cfg, 1, 2'b00, 2);
    do_reset(cfg); req = 4'b0110;
    run_seq('{1, 2, 1, 2, 1, 2, 2, 1}, "R4 three-quarter share");

    // R6/R7/R8: split, blocking, resume boost, stray resume
    cfg = '0;
    cfg = put_ch(cfg, 0, 2'b00, 0); cfg = put_ch(cfg, 1, 2'b00, 1);
    cfg = put_ch(cfg, 2, 2'b00, 2); cfg = put_ch(cfg, 3, 2'b00, 3);
    do_reset(cfg);
    req = 4'b1111; req_slv = 8'b01_00_00_00;
    arb(0, "R6 before split");
    busy_cycle(0, "R6 split cycle hold");
    split_rsp = 1'b1; split_mst = 4'd0; split_slv = 2'd1;
    run_seq('{1, 2, 1, 2}, "R6 R7 masked and blocked");
    busy_cycle(2, "R8 resume cycle hold");
    split_resume = 16'h0001;
    arb(0, "R8 boosted master");
    run_seq('{3, 0, 1}, "R7 unblocked after resume");
    busy_cycle(1, "R8 stray resume cycle");
    split_resume = 16'h0008;
    arb(2, "R8 stray resume ignored");

    // R9: default master when nothing eligible
    cfg = '0; cfg = put_ch(cfg, 0, 2'b00, 1); cfg = put_ch(cfg, 1, 2'b00, 2);
    do_reset(cfg);
    req = 4'b0010;
    arb(1, "R9 real owner");
    sync(); check(parked == 1'b0, "R9 not parked", int'(parked), 0);
    bus_ready = 1'b1; bus_trans = 2'b00; req = 4'b0000;
    begin exp_t e; e.exp = 0; e.tag = "R9 default owner"; exp_q.push_back(e); end
    sync(); check(parked == 1'b1, "R9 parked", int'(parked), 1);

    // R10/R11: timeout to interrupt
    req = 4'b0000; tmo_limit = 16'd6; tmo_to_reset = 1'b0;
    do_reset(cfg);
    bus_ready = 1'b1; bus_trans = 2'b00;
    irq_n = 0; rst_n_cnt = 0; early = 0;
    for (int i = 0; i < 20; i++) begin
      sync();
      if (tmo_irq) irq_n++;
      if (tmo_rst) rst_n_cnt++;
      if (i < 4 && (tmo_irq || tmo_rst)) early++;
    end
    check(early == 0, "R10 no early timeout", early, 0);
    check(irq_n == 1, "R10 R11 single irq pulse", irq_n, 1);
    check(rst_n_cnt == 0, "R11 no reset pulse", rst_n_cnt, 0);

    // R10/R11: NONSEQ clears the count, then route to reset
    tmo_to_reset = 1'b1;
    do_reset(cfg);
    bus_ready = 1'b1; bus_trans = 2'b00;
    irq_n = 0; rst_n_cnt = 0; early = 0;
    for (int i = 0; i < 4; i++) begin
      sync(); if (tmo_irq || tmo_rst) early++;
    end
    sync(); bus_trans = 2'b10;
    sync(); bus_trans = 2'b00;
    if (tmo_irq || tmo_rst) early++;
    for (int i = 0; i < 4; i++) begin
      sync(); if (tmo_irq || tmo_rst) early++;
    end
    check(early == 0, "R10 transfer start clears count", early, 0);
    for (int i = 0; i < 12; i++) begin
      sync();
      if (tmo_irq) irq_n++;
      if (tmo_rst) rst_n_cnt++;
    end
    check(rst_n_cnt == 1, "R11 reset pulse", rst_n_cnt, 1);
    check(irq_n == 0, "R11 no irq pulse", irq_n, 0);

    repeat (3) sync();
    check(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule